// File: doc/BRIEF.md
# Dual-Channel Driver Fault Supervisor

This block supervises the protection state of a four-half-bridge power stage organised as two pairs: pair 0 holds half-bridges A and B, pair 1 holds C and D. It watches a digital junction-temperature code, one overcurrent flag per half-bridge, a vector of supply undervoltage flags, a power-good level and one active-low reset input per pair. From these it drives a disable (high-impedance) request per half-bridge, a weak-pulldown enable per pair, an active-low temperature warning, an active-low fault line and a fault-source vector.

Overcurrent trips are latched per pair. A pair's latch clears only when that pair's own reset input rises. A thermal shutdown is latched for the whole stage. It is released only after each of the two pair resets has produced its own rising edge, and the edges are recorded one at a time. Undervoltage is never latched. It takes effect in the same cycle it appears and goes away without any reset. The pair reset inputs are asynchronous, so they pass through a synchronizer before their level and rising edges are used.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: `warn_n` goes low one cycle after `temp_code` exceeds WARN_CODE (default 125). It returns high only after `temp_code` is at or below WARN_CODE minus WARN_HYST (default 121).
- R2: A `temp_code` strictly above SHUT_CODE (default 150) latches a thermal shutdown. The shutdown sets all four `hiz` bits, drives `fault_n` low and sets `fault_src[0]`. A code equal to SHUT_CODE does not trip.
- R3: A latched thermal shutdown is released only after rising edges of both `pair_rst_n[0]` and `pair_rst_n[1]` have been seen since the trip, in either order. One pair's edge alone leaves it set.
- R4: `oc_flag[0]` or `oc_flag[1]` latches pair 0. This sets `hiz[1:0]` and `fault_src[1]`. `oc_flag[2]` or `oc_flag[3]` latches pair 1, which sets `hiz[3:2]` and `fault_src[2]`. Only a rising edge of the pair's own reset clears its latch.
- R5: A clearing edge that arrives while the cause of the fault is still present does not clear the latch. This holds for an active overcurrent flag of the pair and for a temperature still above SHUT_CODE.
- R6: While `pair_rst_n[p]` (after synchronization) is low, both `hiz` bits of pair p are set and `pulldown_en[p]` is high.
- R7: Any set bit of `uv_flag` sets all `hiz` bits, drives `fault_n` low and sets `fault_src[3]` in the same cycle, without a clock edge. When all bits clear, operation resumes without a reset.
- R8: While `pwr_good` is low, all `hiz` bits are set and both overcurrent latches are held cleared. Overcurrent flags seen during that time leave no fault behind.
- R9: `fault_n` is low exactly when a latched fault or undervoltage is present, and `fault_src` names the source. Bit 0 is thermal, bit 1 is pair 0 overcurrent, bit 2 is pair 1 overcurrent and bit 3 is undervoltage. A warning alone or a held pair reset alone leaves `fault_n` high.
- R10: While `rst_n` is low, all latches and synchronizer stages are cleared. As a result all `hiz` and `pulldown_en` bits are high, and `warn_n` and `fault_n` are high with `fault_src` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| temp_code | input | TEMP_W | Junction temperature code |
| oc_flag | input | 4 | Overcurrent flag per half-bridge (A,B,C,D = bit 0..3) |
| uv_flag | input | UV_N | Undervoltage flag per monitored supply |
| pwr_good | input | 1 | Power-on complete |
| pair_rst_n | input | 2 | Active-low reset per pair, asynchronous |
| hiz | output | 4 | High-impedance request per half-bridge |
| pulldown_en | output | 2 | Weak pulldown enable per pair |
| warn_n | output | 1 | Active-low temperature warning |
| fault_n | output | 1 | Active-low fault |
| fault_src | output | 4 | Fault source vector |

## Verification
The bench targets three corner cases.

- **Thermal release.** A pair-0 edge on its own must not release a thermal latch. A design that cleared on any single edge, or forgot a recorded edge, would either open the bridges early or never reopen them.
- **Clearing against a live cause.** An edge arrives while the overcurrent flag is still high. A design that let the clear win would briefly re-enable a shorted bridge and drop its fault.
- **Boundary codes and hysteresis.** The bench tests temperature codes exactly at the thresholds and inside the hysteresis band, where an off-by-one compare or a missing band shows up as a wrong `warn_n` or a false shutdown.

It also checks that undervoltage acts before the next clock edge, and that overcurrent flags seen before power-good leave nothing latched.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int N_HB   = 4;
  localparam int N_PAIR = 2;

  // fault source vector positions
  localparam int SRC_OT    = 0;
  localparam int SRC_OC_P0 = 1;
  localparam int SRC_OC_P1 = 2;
  localparam int SRC_UV    = 3;
  localparam int SRC_W     = 4;

  // strict "over the limit" compare used by warning and shutdown
  function automatic logic code_over(input int code, input int limit);
    return code > limit;
  endfunction

  // warning state with hysteresis band (limit-hyst, limit]
  function automatic logic warn_step(input logic cur, input int code,
                                     input int limit, input int hyst);
    if (code > limit)              return 1'b1;
    else if (code <= limit - hyst) return 1'b0;
    else                           return cur;
  endfunction

  // pair index that owns a half-bridge
  function automatic int pair_of(input int hb);
    return hb / 2;
  endfunction
endpackage

// File: rtl/bfs_rst_sync.sv
module bfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic lvl_n,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din_n};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_n = sh_q[STAGES-1];
  assign rise  = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/bfs_thermal.sv
module bfs_thermal
  import bfs_pkg::*;
#(
  parameter int TEMP_W    = 8,
  parameter int WARN_CODE = 125,
  parameter int SHUT_CODE = 150,
  parameter int WARN_HYST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [N_PAIR-1:0] pair_rise,
  output logic              warn_q,
  output logic              ot_q
);
  logic              over_shut;
  logic [N_PAIR-1:0] seen_q;
  logic [N_PAIR-1:0] seen_nxt;
  logic              release_ok;

  assign over_shut  = code_over(int'(temp_code), SHUT_CODE);
  assign seen_nxt   = seen_q | pair_rise;
  assign release_ok = ot_q && (&seen_nxt) && !over_shut;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      ot_q   <= 1'b0;
      seen_q <= '0;
    end else begin
      warn_q <= warn_step(warn_q, int'(temp_code), WARN_CODE, WARN_HYST);
      if (over_shut) begin
        ot_q   <= 1'b1;
        seen_q <= '0;
      end else if (release_ok) begin
        ot_q   <= 1'b0;
        seen_q <= '0;
      end else if (ot_q) begin
        seen_q <= seen_nxt;
      end else begin
        seen_q <= '0;
      end
    end
  end
endmodule

// File: rtl/bfs_oc_latch.sv
module bfs_oc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic oc_hit,
  input  logic rise,
  output logic latched
);
  always_ff @(posedge clk) begin
    if (!rst_n)        latched <= 1'b0;
    else if (!pwr_good) latched <= 1'b0;
    else if (oc_hit)   latched <= 1'b1;
    else if (rise)     latched <= 1'b0;
  end
endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor
  import bfs_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int UV_N        = 2,
  parameter int WARN_CODE   = 125,
  parameter int SHUT_CODE   = 150,
  parameter int WARN_HYST   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [3:0]        oc_flag,
  input  logic [UV_N-1:0]   uv_flag,
  input  logic              pwr_good,
  input  logic [1:0]        pair_rst_n,
  output logic [3:0]        hiz,
  output logic [1:0]        pulldown_en,
  output logic              warn_n,
  output logic              fault_n,
  output logic [3:0]        fault_src
);
  logic [N_PAIR-1:0] pair_lvl_n;
  logic [N_PAIR-1:0] pair_rise;
  logic [N_PAIR-1:0] oc_latched;
  logic              warn_q;
  logic              ot_q;
  logic              uv_any;
  logic              stage_off;

  genvar p;
  generate
    for (p = 0; p < N_PAIR; p++) begin : g_pair
      bfs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din_n (pair_rst_n[p]),
        .lvl_n (pair_lvl_n[p]),
        .rise  (pair_rise[p])
      );
      bfs_oc_latch u_oc (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .oc_hit   (oc_flag[2*p] | oc_flag[2*p+1]),
        .rise     (pair_rise[p]),
        .latched  (oc_latched[p])
      );
      assign pulldown_en[p] = ~pair_lvl_n[p];
    end
  endgenerate

  bfs_thermal #(
    .TEMP_W    (TEMP_W),
    .WARN_CODE (WARN_CODE),
    .SHUT_CODE (SHUT_CODE),
    .WARN_HYST (WARN_HYST)
  ) u_therm (
    .clk       (clk),
    .rst_n     (rst_n),
    .temp_code (temp_code),
    .pair_rise (pair_rise),
    .warn_q    (warn_q),
    .ot_q      (ot_q)
  );

  assign uv_any    = |uv_flag;
  assign stage_off = uv_any | ot_q | ~pwr_good;

  genvar h;
  generate
    for (h = 0; h < N_HB; h++) begin : g_hb
      localparam int PI = pair_of(h);
      assign hiz[h] = stage_off | oc_latched[PI] | ~pair_lvl_n[PI];
    end
  endgenerate

  assign fault_src[SRC_OT]    = ot_q;
  assign fault_src[SRC_OC_P0] = oc_latched[0];
  assign fault_src[SRC_OC_P1] = oc_latched[1];
  assign fault_src[SRC_UV]    = uv_any;
  assign fault_n = ~(ot_q | (|oc_latched) | uv_any);
  assign warn_n  = ~warn_q;
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
  parameter int TEMP_W    = 8,
  parameter int UV_N      = 2,
  parameter int WARN_CODE = 125,
  parameter int WARN_HYST = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TEMP_W-1:0] temp_code,
  input logic [3:0]        oc_flag,
  input logic [UV_N-1:0]   uv_flag,
  input logic              pwr_good,
  input logic [3:0]        hiz,
  input logic [1:0]        pulldown_en,
  input logic              warn_n,
  input logic              fault_n,
  input logic [3:0]        fault_src,
  input logic [1:0]        pair_rise
);
  // R1
  warn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(temp_code) > WARN_CODE) |=> !warn_n);
  // R1
  warn_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(temp_code) <= WARN_CODE - WARN_HYST) |=> warn_n);
  // R2
  ot_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_src[0] |-> (hiz == 4'hF && !fault_n));
  // R3
  ot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_src[0]) |-> $past(|pair_rise));
  // R4
  oc_p0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_src[1]) |-> $past(pair_rise[0] || !pwr_good));
  // R4
  oc_p1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_src[2]) |-> $past(pair_rise[1] || !pwr_good));
  // R5
  oc_live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_rise[0] && (oc_flag[0] || oc_flag[1]) && pwr_good) |=> fault_src[1]);
  // R6
  pd_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulldown_en[0] |-> (hiz[1:0] == 2'b11));
  // R6
  pd_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulldown_en[1] |-> (hiz[3:2] == 2'b11));
  // R7
  uv_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|uv_flag) |-> (hiz == 4'hF && !fault_n && fault_src[3]));
  // R8
  pg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!fault_src[1] && !fault_src[2]));
endmodule

bind bridge_fault_supervisor bfs_checker #(
  .TEMP_W    (TEMP_W),
  .UV_N      (UV_N),
  .WARN_CODE (WARN_CODE),
  .WARN_HYST (WARN_HYST)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .temp_code   (temp_code),
  .oc_flag     (oc_flag),
  .uv_flag     (uv_flag),
  .pwr_good    (pwr_good),
  .hiz         (hiz),
  .pulldown_en (pulldown_en),
  .warn_n      (warn_n),
  .fault_n     (fault_n),
  .fault_src   (fault_src),
  .pair_rise   (pair_rise)
);

// File: tb/bridge_fault_supervisor_tb.sv
module bridge_fault_supervisor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] temp_code = 8'd25;
  logic [3:0] oc_flag = '0;
  logic [1:0] uv_flag = '0;
  logic       pwr_good = 1'b1;
  logic [1:0] pair_rst_n = 2'b11;
  logic [3:0] hiz;
  logic [1:0] pulldown_en;
  logic       warn_n, fault_n;
  logic [3:0] fault_src;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bridge_fault_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .oc_flag(oc_flag),
    .uv_flag(uv_flag), .pwr_good(pwr_good), .pair_rst_n(pair_rst_n),
    .hiz(hiz), .pulldown_en(pulldown_en), .warn_n(warn_n),
    .fault_n(fault_n), .fault_src(fault_src)
  );

  // {temp, oc, uv, pg, prst} | {hiz, pd, warn_n, fault_n, src}
  localparam int NV = 31;
  localparam logic [28:0] VEC [NV] = '{
    {8'd25, 4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b1,1'b1,4'b0000}, // R9 idle
    {8'd126,4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b0,1'b1,4'b0000}, // R1 trip
    {8'd123,4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b0,1'b1,4'b0000}, // R1 band
    {8'd121,4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b1,1'b1,4'b0000}, // R1 release
    {8'd125,4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b1,1'b1,4'b0000}, // R1 equal
    {8'd25, 4'b0001,2'b00,1'b1,2'b11, 4'b0011,2'b00,1'b1,1'b0,4'b0010}, // R4 A trip
    {8'd25, 4'b0000,2'b00,1'b1,2'b11, 4'b0011,2'b00,1'b1,1'b0,4'b0010}, // R4 held
    {8'd25, 4'b0000,2'b00,1'b1,2'b10, 4'b0011,2'b01,1'b1,1'b0,4'b0010}, // R6 p0 low
    {8'd25, 4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b1,1'b1,4'b0000}, // R4 cleared
    {8'd25, 4'b1000,2'b00,1'b1,2'b11, 4'b1100,2'b00,1'b1,1'b0,4'b0100}, // R4 D trip
    {8'd25, 4'b0000,2'b00,1'b1,2'b10, 4'b1111,2'b01,1'b1,1'b0,4'b0100}, // R6
    {8'd25, 4'b0000,2'b00,1'b1,2'b11, 4'b1100,2'b00,1'b1,1'b0,4'b0100}, // R4 wrong pair
    {8'd25, 4'b0000,2'b00,1'b1,2'b01, 4'b1100,2'b10,1'b1,1'b0,4'b0100}, // R6 p1 low
    {8'd25, 4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b1,1'b1,4'b0000}, // R4 cleared
    {8'd25, 4'b0100,2'b00,1'b1,2'b01, 4'b1100,2'b10,1'b1,1'b0,4'b0100}, // R5 setup
    {8'd25, 4'b0100,2'b00,1'b1,2'b11, 4'b1100,2'b00,1'b1,1'b0,4'b0100}, // R5 live edge
    {8'd25, 4'b0000,2'b00,1'b1,2'b11, 4'b1100,2'b00,1'b1,1'b0,4'b0100}, // R5 still set
    {8'd25, 4'b0000,2'b00,1'b1,2'b01, 4'b1100,2'b10,1'b1,1'b0,4'b0100}, // R4
    {8'd25, 4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b1,1'b1,4'b0000}, // R4 cleared
    {8'd151,4'b0000,2'b00,1'b1,2'b11, 4'b1111,2'b00,1'b0,1'b0,4'b0001}, // R2 trip
    {8'd100,4'b0000,2'b00,1'b1,2'b11, 4'b1111,2'b00,1'b1,1'b0,4'b0001}, // R2 latched
    {8'd100,4'b0000,2'b00,1'b1,2'b10, 4'b1111,2'b01,1'b1,1'b0,4'b0001}, // R3
    {8'd100,4'b0000,2'b00,1'b1,2'b11, 4'b1111,2'b00,1'b1,1'b0,4'b0001}, // R3 one edge
    {8'd100,4'b0000,2'b00,1'b1,2'b01, 4'b1111,2'b10,1'b1,1'b0,4'b0001}, // R3
    {8'd100,4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b1,1'b1,4'b0000}, // R3 both
    {8'd100,4'b0000,2'b01,1'b1,2'b11, 4'b1111,2'b00,1'b1,1'b0,4'b1000}, // R7 uv
    {8'd100,4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b1,1'b1,4'b0000}, // R7 recover
    {8'd100,4'b0001,2'b00,1'b0,2'b11, 4'b1111,2'b00,1'b1,1'b1,4'b0000}, // R8 pg low
    {8'd100,4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b1,1'b1,4'b0000}, // R8 no residue
    {8'd150,4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b0,1'b1,4'b0000}, // R2 equal code
    {8'd100,4'b0000,2'b00,1'b1,2'b11, 4'b0000,2'b00,1'b1,1'b1,4'b0000}  // R1
  };

  task automatic check(input string tag, input logic [11:0] exp);
    logic [11:0] act;
    act = {hiz, pulldown_en, warn_n, fault_n, fault_src};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got hiz/pd/warn/fault/src=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        #(200000 * 4);
        if (!done) begin
          n_chk++;
          n_bad++;
          $display("FAIL watchdog: run did not finish, expected completion");
          $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
          $finish;
        end
      end
    join_none

    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 reset", {4'b1111, 2'b11, 1'b1, 1'b1, 4'b0000});
    rst_n = 1'b1;
    settle();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {temp_code, oc_flag, uv_flag, pwr_good, pair_rst_n} = VEC[i][28:12];
      settle();
      check($sformatf("vector %0d", i), VEC[i][11:0]);
    end

    // R7 same-cycle undervoltage response, before any clock edge
    @(negedge clk);
    uv_flag = 2'b10;
    #1;
    check("R7 immediate", {4'b1111, 2'b00, 1'b1, 1'b0, 4'b1000});
    uv_flag = 2'b00;
    #0.5;
    check("R7 immediate release", {4'b0000, 2'b00, 1'b1, 1'b1, 4'b0000});

    // R10 block reset clears a latched overcurrent
    @(negedge clk);
    oc_flag = 4'b0010;
    settle();
    oc_flag = 4'b0000;
    check("R4 B trip", {4'b0011, 2'b00, 1'b1, 1'b0, 4'b0010});
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 reset mid-run", {4'b1111, 2'b11, 1'b1, 1'b1, 4'b0000});
    rst_n = 1'b1;
    settle();
    check("R10 after reset", {4'b0000, 2'b00, 1'b1, 1'b1, 4'b0000});

    // R3 reverse order: pair 1 edge first, then pair 0
    temp_code = 8'd200;
    settle();
    temp_code = 8'd50;
    pair_rst_n = 2'b01;
    settle();
    pair_rst_n = 2'b11;
    settle();
    check("R3 one edge reverse", {4'b1111, 2'b00, 1'b1, 1'b0, 4'b0001});
    pair_rst_n = 2'b10;
    settle();
    pair_rst_n = 2'b11;
    settle();
    check("R3 both reverse", {4'b0000, 2'b00, 1'b1, 1'b1, 4'b0000});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule